// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte stream into memory. Software builds a circular chain of descriptors. Each descriptor takes four aligned 32-bit words. The engine reads a descriptor and checks its hold flag. It then gathers the stream bytes into 32-bit words and writes them into the descriptor's buffer. When the frame ends, it writes the descriptor's status word and moves on to the address held in the descriptor's link word.

Software controls the engine with two pulses. A start pulse, given while the engine is stopped, loads the first descriptor address and starts the engine. A stop pulse lets the engine finish the descriptor it is working on and then halt. A descriptor that software still holds is re-read after a fixed number of idle cycles until it is released. All memory traffic goes through one request/acknowledge port.

Top module: `rxd_ring_writer`

## Requirements
- R1: A descriptor at address D is laid out as follows: D+0 holds the control word, D+4 holds the link to the next descriptor, D+8 holds the buffer address and D+12 holds the status word. The engine reads D+0, then D+4, then D+8. It writes the status to D+12. A memory request holds its address stable until it is acknowledged.
- R2: If bit 31 of the control word is set, the descriptor is held. The engine accepts no stream byte (rx_ready_o stays low) and writes nothing to memory until software clears that bit.
- R3: While a descriptor is held, the engine waits POLL_CYCLES idle cycles (default 7) before it reads the control word again. With a memory that acknowledges one cycle after a request, two reads of a held control word are therefore POLL_CYCLES+2 cycles apart.
- R4: Frame bytes are packed little-endian: byte k of the frame goes to byte lane k mod 4 of the word at buffer+4*(k div 4). The byte enable of the last, partial word has bit n set for each lane n that holds frame data. No buffer word is written twice for one frame.
- R5: The status word has bit 31 (done) set, bit 30 (frame start) set, and bit 29 (frame end) set when the whole frame was stored. Bits 16:0 give the stored byte count. This count includes the trailing 4-byte check sequence, which arrives in the stream.
- R6: Bits 21:0 of the control word give the buffer size in bytes. Bytes past that size are dropped. The status word then reports the size as the count and has bit 29 clear.
- R7: The status word is written only after every data word of the frame has been written.
- R8: After the status write, the engine continues at the descriptor named by the link word. When the last descriptor links back to the first, the ring wraps.
- R9: A stop pulse lets the current descriptor complete and then halts the engine. A halted engine makes no memory requests and holds rx_ready_o low.
- R10: A start pulse given while the engine is halted loads first_desc_i and starts fetching there.
- R11: After reset the engine is halted, with mem_req_o and rx_ready_o low.
- R12: Bytes that arrive before a start marker, while no frame is in progress, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_init_i | input | 1 | Start pulse; loads the first descriptor address |
| cmd_off_i | input | 1 | Stop pulse; halts after the current descriptor |
| first_desc_i | input | AW | Address of the first descriptor |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_sop_i | input | 1 | Byte is the first of a frame |
| rx_eop_i | input | 1 | Byte is the last of a frame |
| rx_ready_o | output | 1 | Engine takes the stream byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_ack_i | input | 1 | Request done; read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
A wrong descriptor pointer shows up within a few cycles at the memory port, as a read or status write at an unexpected address. A lost or doubled lane count shows up as a mismatch on the next data word or byte enable. A stale truncation flag or byte count appears in the very next status word. A wrong hold or stop decision appears at once as rx_ready_o rising, or as memory requests while the engine should be quiet. The polling counter can be checked from the spacing of the control-word reads.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W   = 32;
  localparam int LANES    = 4;
  localparam int HOLD_BIT = 31;
  localparam int SIZE_W   = 22;
  localparam int ST_DONE  = 31;
  localparam int ST_SOP   = 30;
  localparam int ST_EOP   = 29;
  localparam int CNT_W    = 17;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_CTL, S_POLL, S_RD_LINK, S_RD_BUF, S_RECV, S_WR_DATA, S_WR_STAT
  } rxd_state_e;

  function automatic logic [WORD_W-1:0] status_word(input logic whole,
                                                    input logic [CNT_W-1:0] cnt);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ST_DONE] = 1'b1;
    w[ST_SOP]  = 1'b1;
    w[ST_EOP]  = whole;
    w[CNT_W-1:0] = cnt;
    return w;
  endfunction
endpackage

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer #(
  parameter int LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [7:0]         byte_i,
  input  logic               pop_i,
  output logic [LANES*8-1:0] word_o,
  output logic [LANES-1:0]   be_o,
  output logic               fills_o,
  output logic               any_o
);
  logic [LANES-1:0] be_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       sel;
    // lane g is next when all lower lanes hold data and it does not
    if (g == 0) begin : g_first
      assign sel = !be_q[0];
    end else begin : g_rest
      assign sel = be_q[g-1] && !be_q[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q  <= '0;
        be_q[g] <= 1'b0;
      end else if (pop_i) begin
        lane_q  <= '0;
        be_q[g] <= 1'b0;
      end else if (push_i && sel) begin
        lane_q  <= byte_i;
        be_q[g] <= 1'b1;
      end
    end
    assign word_o[g*8 +: 8] = lane_q;
  end

  assign be_o    = be_q;
  assign fills_o = be_q[LANES-2];
  assign any_o   = be_q[0];

  // R4
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !be_q[LANES-1]);
  // R4
  push_pop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
  parameter int CYCLES = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(CYCLES - 1));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
  import rxd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int POLL_CYCLES = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_init_i,
  input  logic              cmd_off_i,
  input  logic [AW-1:0]     first_desc_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_sop_i,
  input  logic              rx_eop_i,
  output logic              rx_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int PAD = SIZE_W - CNT_W;

  rxd_state_e        st_q, st_d;
  logic [AW-1:0]     cur_q, link_q, wr_q;
  logic [SIZE_W-1:0] max_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              trunc_q, last_q, in_frame_q, off_q;

  logic              pk_push, pk_pop, pk_fills, pk_any;
  logic [WORD_W-1:0] pk_word;
  logic [LANES-1:0]  pk_be;
  logic              tmr_done;
  logic              take, accept, room, store, flush;
  logic [SIZE_W-1:0] cnt_ext, cnt_inc;

  rxd_byte_packer #(.LANES(LANES)) u_packer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (pk_push),
    .byte_i (rx_data_i),
    .pop_i  (pk_pop),
    .word_o (pk_word),
    .be_o   (pk_be),
    .fills_o(pk_fills),
    .any_o  (pk_any)
  );

  rxd_poll_timer #(.CYCLES(POLL_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st_q == S_POLL),
    .done_o(tmr_done)
  );

  assign cnt_ext = {{PAD{1'b0}}, cnt_q};
  assign cnt_inc = cnt_ext + 1'b1;
  assign take    = rx_ready_o && rx_valid_i;
  assign accept  = take && (in_frame_q || rx_sop_i);
  assign room    = cnt_ext < max_q;
  assign store   = accept && room;
  assign flush   = store && (pk_fills || rx_eop_i || (cnt_inc == max_q));

  always_comb begin
    st_d        = st_q;
    rx_ready_o  = (st_q == S_RECV);
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = pk_word;
    mem_be_o    = '1;
    pk_push     = 1'b0;
    pk_pop      = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_init_i) st_d = S_RD_CTL;
      S_RD_CTL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          if (mem_rdata_i[HOLD_BIT]) st_d = off_q ? S_IDLE : S_POLL;
          else                       st_d = S_RD_LINK;
        end
      end
      S_POLL: begin
        if (off_q)         st_d = S_IDLE;
        else if (tmr_done) st_d = S_RD_CTL;
      end
      S_RD_LINK: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(4);
        if (mem_ack_i) st_d = S_RD_BUF;
      end
      S_RD_BUF: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(8);
        if (mem_ack_i) st_d = S_RECV;
      end
      S_RECV: begin
        pk_push = store;
        if (flush)                    st_d = S_WR_DATA;
        else if (accept && rx_eop_i)  st_d = S_WR_STAT;
      end
      S_WR_DATA: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = wr_q;
        mem_be_o   = pk_be;
        if (mem_ack_i) begin
          pk_pop = 1'b1;
          st_d   = last_q ? S_WR_STAT : S_RECV;
        end
      end
      S_WR_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + AW'(12);
        mem_wdata_o = status_word(!trunc_q, cnt_q);
        if (mem_ack_i) st_d = off_q ? S_IDLE : S_RD_CTL;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      cur_q      <= '0;
      link_q     <= '0;
      wr_q       <= '0;
      max_q      <= '0;
      cnt_q      <= '0;
      trunc_q    <= 1'b0;
      last_q     <= 1'b0;
      in_frame_q <= 1'b0;
      off_q      <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE) begin
        off_q <= 1'b0;
        if (cmd_init_i) cur_q <= first_desc_i;
      end else if (st_d == S_IDLE) begin
        off_q <= 1'b0;
      end else if (cmd_off_i) begin
        off_q <= 1'b1;
      end
      if (mem_ack_i) begin
        unique case (st_q)
          S_RD_CTL:  max_q  <= mem_rdata_i[SIZE_W-1:0];
          S_RD_LINK: link_q <= mem_rdata_i[AW-1:0];
          S_RD_BUF: begin
            wr_q       <= mem_rdata_i[AW-1:0];
            cnt_q      <= '0;
            trunc_q    <= 1'b0;
            last_q     <= 1'b0;
            in_frame_q <= 1'b0;
          end
          S_WR_DATA: wr_q  <= wr_q + AW'(4);
          S_WR_STAT: cur_q <= link_q;
          default: ;
        endcase
      end
      if (st_q == S_RECV && accept) begin
        in_frame_q <= 1'b1;
        if (room) cnt_q   <= cnt_q + 1'b1;
        else      trunc_q <= 1'b1;
        if (rx_eop_i) last_q <= 1'b1;
      end
    end
  end

  // R1
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R2
  hold_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RD_CTL && mem_ack_i && mem_rdata_i[HOLD_BIT]) |=> !rx_ready_o);
  // R7
  stat_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WR_STAT) |-> !pk_any);
  // R6
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WR_STAT) |-> ({{PAD{1'b0}}, mem_wdata_o[CNT_W-1:0]} <= max_q));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE) |-> (!mem_req_o && !rx_ready_o));
endmodule

// File: tb/rxd_ring_writer_bench.sv
module rxd_ring_writer_bench;
  localparam int AW   = 32;
  localparam int POLL = 7;
  localparam logic [31:0] D0 = 32'h100, D1 = 32'h110, D2 = 32'h120;
  localparam logic [31:0] B0 = 32'h200, B1 = 32'h240, B2 = 32'h280;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_init = 1'b0, cmd_off = 1'b0;
  logic [31:0] first_desc = '0;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [0:255];
  logic [67:0] exp_q [$];
  string       tag_q [$];
  int          checks = 0, errors = 0;
  int          cyc = 0, last_poll = -1, poll_gap = -1;
  bit          done_flag = 1'b0;

  always #2.5 clk = ~clk;

  rxd_ring_writer #(.AW(AW), .POLL_CYCLES(POLL)) u_rxd_ring_writer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_init_i(cmd_init), .cmd_off_i(cmd_off),
    .first_desc_i(first_desc), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sop_i(rx_sop), .rx_eop_i(rx_eop), .rx_ready_o(rx_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  // memory slave: acknowledges one cycle after a request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else begin
          mem_rdata <= mem[mem_addr[9:2]];
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [67:0] act,
                       input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: compares each write as it is presented
  always @(negedge clk) begin
    cyc++;
    if (rst_n && mem_req && !mem_ack) begin
      if (mem_we) begin
        logic [67:0] act, exp;
        logic [31:0] m;
        string tg;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 R9 unexpected write", {mem_addr, mem_wdata, mem_be}, '0);
        end else begin
          exp = exp_q.pop_front();
          tg  = tag_q.pop_front();
          m = {{8{exp[3]}}, {8{exp[2]}}, {8{exp[1]}}, {8{exp[0]}}};
          act = {mem_addr, mem_wdata & m, mem_be};
          check(act == exp, tg, act, exp);
        end
      end else if (mem_addr == D2) begin
        if (last_poll >= 0) poll_gap = cyc - last_poll;
        last_poll = cyc;
      end
    end
  end

  // driver: pushes expected writes, then streams the frame
  task automatic send_frame(input int n, input logic [7:0] seed, input int max,
                            input logic [31:0] bufa, input logic [31:0] desc,
                            input string tg);
    int stored;
    logic [31:0] w;
    logic [3:0]  be;
    stored = (n < max) ? n : max;
    for (int k = 0; k < (stored + 3) / 4; k++) begin
      w = '0; be = '0;
      for (int l = 0; l < 4; l++)
        if (k*4 + l < stored) begin
          w[l*8 +: 8] = seed + 8'(k*4 + l);
          be[l] = 1'b1;
        end
      exp_q.push_back({bufa + 32'(k*4), w, be});
      tag_q.push_back({tg, " R4 data word"});
    end
    exp_q.push_back({desc + 32'd12, 1'b1, 1'b1, (n <= max), 12'b0, 17'(stored), 4'hF});
    tag_q.push_back({tg, " R1 R5 R6 R7 status"});
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = seed + 8'(i);
      rx_sop   = (i == 0);
      rx_eop   = (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R7 writes pending", 68'(exp_q.size()), '0);
  endtask

  task automatic pulse_init(input logic [31:0] a);
    first_desc = a; cmd_init = 1'b1;
    @(negedge clk);
    cmd_init = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[D0[9:2]]     = 32'd64;  mem[D0[9:2] + 1] = D1; mem[D0[9:2] + 2] = B0;
    mem[D1[9:2]]     = 32'd6;   mem[D1[9:2] + 1] = D2; mem[D1[9:2] + 2] = B1;
    mem[D2[9:2]]     = 32'h8000_0040; mem[D2[9:2] + 1] = D0; mem[D2[9:2] + 2] = B2;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!mem_req && !rx_ready, "R11 reset outputs", {mem_req, rx_ready}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!mem_req && !rx_ready, "R11 idle after reset", {mem_req, rx_ready}, '0);

    // R10 start at D0; R12 stray byte dropped
    pulse_init(D0);
    rx_valid = 1'b1; rx_data = 8'hEE;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    send_frame(9, 8'h10, 64, B0, D0, "R12 F1");
    // R6 truncation at size 6
    send_frame(10, 8'h40, 6, B1, D1, "R6 F2");
    wait_drain();

    // R2 held descriptor D2
    begin
      bit rdy_seen = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (rx_ready) rdy_seen = 1'b1;
      end
      check(!rdy_seen, "R2 ready while held", 68'(rdy_seen), '0);
    end
    // R3 re-poll spacing
    check(poll_gap == POLL + 2, "R3 poll gap", 68'(poll_gap), 68'(POLL + 2));
    mem[D2[9:2]] = 32'd64;
    send_frame(4, 8'h80, 64, B2, D2, "R2 F3");
    // R8 wrap back to D0
    send_frame(5, 8'h90, 64, B0, D0, "R8 F4");
    wait_drain();
    repeat (20) @(negedge clk);

    // R9 stop while waiting on D1
    cmd_off = 1'b1;
    @(negedge clk);
    cmd_off = 1'b0;
    send_frame(3, 8'hA0, 6, B1, D1, "R9 F5");
    wait_drain();
    repeat (3) @(negedge clk);
    begin
      bit busy = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (mem_req || rx_ready) busy = 1'b1;
      end
      check(!busy, "R9 quiet after stop", 68'(busy), '0);
    end

    // R10 restart at D2
    pulse_init(D2);
    send_frame(2, 8'hC0, 64, B2, D2, "R10 F6");
    wait_drain();
    repeat (5) @(negedge clk);
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule